// File: doc/BRIEF.md
# Predicated Register ALU with Single-Bit Test Flag

This block is the execute stage of a compact 8-bit processor. Each issued instruction presents two register operands, a major opcode and a three-bit group selector. The logic/shift family produces a result word and a one-cycle write-back strobe, and the register file stores that word into the left-hand (destination) register. The compare family produces no result word. It only updates a single-bit test flag that later instructions can read.

Every instruction carries two predicate bits. One bit lets the instruction run only while the test flag is set. The other lets it run only while the flag is clear. When the predicate fails, the instruction has no effect: no write-back strobe, no change to the result, and no change to the flag. The surrounding core issues at most one instruction per two-cycle instruction slot. Results and the flag become visible one clock edge after the issue.

Top module: `pred_alu`

## Requirements
- R1: With `opcode`=4, group 0/1/2 gives `opA & opB`, `opA | opB` and `opA ^ opB`, and group 3 gives `~opB`. Each one is presented on `result` together with `resultWe`=1.
- R2: With `opcode`=4, group 4 shifts `opA` left and group 5 shifts it right. The shift amount is `opB[2:0]` and vacated bits fill with zeros.
- R3: With `opcode`=4, group 6 rotates `opA` left and group 7 rotates it right, by `opB[2:0]` positions.
- R4: With `opcode`=3, groups 0..5 load `trFlag` with the unsigned truth of opA>opB, opA>=opB, opA<opB, opA<=opB, opA==opB and opA!=opB, in that order.
- R5: With `opcode`=3, group 6 loads `trFlag` with (opA==0) and group 7 loads it with (opA!=0). `opB` has no effect on either.
- R6: A compare never raises `resultWe` and leaves `result` unchanged. A logic/shift operation leaves `trFlag` unchanged.
- R7: With `condSet`=1 (and `condClear`=0), an instruction takes effect only when `trFlag` is 1.
- R8: With `condClear`=1 (and `condSet`=0), an instruction takes effect only when `trFlag` is 0. With both bits set, it never takes effect.
- R9: Any opcode other than 3 or 4 leaves `resultWe` low and leaves `result` and `trFlag` unchanged.
- R10: While `rstN` is low, `trFlag`, `result` and `resultWe` are all 0.
- R11: The effects of an instruction issued at a rising edge appear right after that edge. `resultWe` stays high for only that one cycle, and `result` holds its value until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | An instruction is presented this cycle |
| opcode | input | 3 | Major opcode (3 compare, 4 logic/shift) |
| group | input | 3 | Operation selector within the major opcode |
| condSet | input | 1 | Predicate: run only while the flag is set |
| condClear | input | 1 | Predicate: run only while the flag is clear |
| opA | input | DATA_W | Left (destination) register operand |
| opB | input | DATA_W | Right register operand |
| result | output | DATA_W | Last result written back |
| resultWe | output | 1 | Write-back strobe for the destination register |
| trFlag | output | 1 | Test-result flag |

## Verification
The bench builds the block with the default width of 8. This makes the shift amount exactly three bits wide. Shift operands with higher bits set in `opB` therefore show that only the low bits count, and a rotate by seven can be checked against a rotate by one in the other direction. At this width the unsigned compares can be probed with operands above 0x7F, where a signed reading would give the opposite answer. The stimulus table is ordered so that the flag state built up by the compares drives the later predicated cases through pass, fail and never-run outcomes.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;
  localparam logic [2:0] OP_CMP   = 3'd3;
  localparam logic [2:0] OP_LOGIC = 3'd4;

  typedef struct packed {
    logic       logicEn;
    logic       cmpEn;
    logic [2:0] grp;
  } aluStrobe_t;
endpackage

// File: rtl/pred_alu_ctrl.sv
module pred_alu_ctrl
  import pred_alu_pkg::*;
(
  input  logic       issue,
  input  logic [2:0] opcode,
  input  logic [2:0] group,
  input  logic       condSet,
  input  logic       condClear,
  input  logic       trQ,
  output aluStrobe_t strobe
);
  logic condPass;

  // Set-predicate needs flag high, clear-predicate needs flag low; both => never.
  assign condPass = (!condSet || trQ) && (!condClear || !trQ);

  always_comb begin
    strobe.logicEn = issue && condPass && (opcode == OP_LOGIC);
    strobe.cmpEn   = issue && condPass && (opcode == OP_CMP);
    strobe.grp     = group;
  end
endmodule

// File: rtl/pred_alu_dp.sv
module pred_alu_dp
  import pred_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic              trQ
);
  localparam int SH_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [SH_W-1:0]     amt;
  logic [2*DATA_W-1:0] rotL;
  logic [2*DATA_W-1:0] rotR;
  logic [DATA_W-1:0]   logicVal;
  logic                cmpVal;
  logic [DATA_W-1:0]   resultQ;
  logic                weQ;
  logic                trReg;

  assign amt  = opB[SH_W-1:0];
  assign rotL = {opA, opA} << amt;
  assign rotR = {opA, opA} >> amt;

  always_comb begin
    unique case (strobe.grp)
      3'd0: logicVal = opA & opB;
      3'd1: logicVal = opA | opB;
      3'd2: logicVal = opA ^ opB;
      3'd3: logicVal = ~opB;
      3'd4: logicVal = opA << amt;
      3'd5: logicVal = opA >> amt;
      3'd6: logicVal = rotL[2*DATA_W-1:DATA_W];
      default: logicVal = rotR[DATA_W-1:0];
    endcase
  end

  always_comb begin
    unique case (strobe.grp)
      3'd0: cmpVal = opA > opB;
      3'd1: cmpVal = opA >= opB;
      3'd2: cmpVal = opA < opB;
      3'd3: cmpVal = opA <= opB;
      3'd4: cmpVal = opA == opB;
      3'd5: cmpVal = opA != opB;
      3'd6: cmpVal = (opA == '0);
      default: cmpVal = (opA != '0);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      weQ     <= 1'b0;
      trReg   <= 1'b0;
    end else begin
      weQ <= strobe.logicEn;
      if (strobe.logicEn) resultQ <= logicVal;
      if (strobe.cmpEn)   trReg   <= cmpVal;
    end
  end

  assign result   = resultQ;
  assign resultWe = weQ;
  assign trQ      = trReg;

  assert_tr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cmpEn |=> $stable(trQ));
  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmpEn |=> !resultWe);
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.logicEn |=> $stable(result));
endmodule

// File: rtl/pred_alu.sv
module pred_alu
  import pred_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [2:0]        opcode,
  input  logic [2:0]        group,
  input  logic              condSet,
  input  logic              condClear,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic              trFlag
);
  aluStrobe_t strobe;

  pred_alu_ctrl ctrl_i (
    .issue(issue), .opcode(opcode), .group(group),
    .condSet(condSet), .condClear(condClear), .trQ(trFlag), .strobe(strobe)
  );

  pred_alu_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .result(result), .resultWe(resultWe), .trQ(trFlag)
  );

  assert_cond_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (issue && condSet && !trFlag) |=> (!resultWe && !trFlag));
  assert_cond_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issue && condClear && trFlag) |=> (!resultWe && trFlag));
  assert_zero_test_R5: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode == OP_CMP && group == 3'd6 && !condSet && !condClear)
      |=> (trFlag == ($past(opA) == '0)));
  assert_other_op_R9: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode != OP_CMP && opcode != OP_LOGIC) |=> (!resultWe && $stable(trFlag)));
  assert_reset_R10: assert property (@(posedge clk)
    !rstN |-> (!resultWe && !trFlag && result == '0));
endmodule

// File: tb/pred_alu_tb_top.sv
module pred_alu_tb_top;
  typedef struct packed {
    logic [2:0] op;
    logic [2:0] grp;
    logic       cs;
    logic       cc;
    logic [7:0] a;
    logic [7:0] b;
    logic       expWe;
    logic [7:0] expRes;
    logic       expTr;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{3'd4,3'd0,1'b0,1'b0,8'hF0,8'h3C,1'b1,8'h30,1'b0}, // R1 and
    '{3'd4,3'd1,1'b0,1'b0,8'h0F,8'h30,1'b1,8'h3F,1'b0}, // R1 or
    '{3'd4,3'd2,1'b0,1'b0,8'hA5,8'hFF,1'b1,8'h5A,1'b0}, // R1 xor
    '{3'd4,3'd3,1'b0,1'b0,8'h12,8'h0F,1'b1,8'hF0,1'b0}, // R1 not
    '{3'd4,3'd4,1'b0,1'b0,8'h81,8'h03,1'b1,8'h08,1'b0}, // R2 shl
    '{3'd4,3'd5,1'b0,1'b0,8'h81,8'h0B,1'b1,8'h10,1'b0}, // R2 shr, amount 3
    '{3'd4,3'd6,1'b0,1'b0,8'h81,8'h01,1'b1,8'h03,1'b0}, // R3 rol
    '{3'd4,3'd7,1'b0,1'b0,8'h81,8'h02,1'b1,8'h60,1'b0}, // R3 ror
    '{3'd3,3'd0,1'b0,1'b0,8'h90,8'h7F,1'b0,8'h60,1'b1}, // R4 gt unsigned
    '{3'd3,3'd1,1'b0,1'b0,8'h05,8'h05,1'b0,8'h60,1'b1}, // R4 gte
    '{3'd3,3'd2,1'b0,1'b0,8'h05,8'h05,1'b0,8'h60,1'b0}, // R4 lt
    '{3'd3,3'd3,1'b0,1'b0,8'h04,8'h05,1'b0,8'h60,1'b1}, // R4 lte
    '{3'd3,3'd4,1'b0,1'b0,8'h33,8'h34,1'b0,8'h60,1'b0}, // R4 eq
    '{3'd3,3'd5,1'b0,1'b0,8'h33,8'h34,1'b0,8'h60,1'b1}, // R4 neq
    '{3'd3,3'd6,1'b0,1'b0,8'h00,8'h55,1'b0,8'h60,1'b1}, // R5 eqz
    '{3'd3,3'd7,1'b0,1'b0,8'h00,8'h55,1'b0,8'h60,1'b0}, // R5 neqz
    '{3'd3,3'd6,1'b0,1'b0,8'h01,8'h00,1'b0,8'h60,1'b0}, // R5 eqz ignores b
    '{3'd4,3'd0,1'b1,1'b0,8'hFF,8'hFF,1'b0,8'h60,1'b0}, // R7 fails
    '{3'd4,3'd1,1'b0,1'b1,8'h01,8'h02,1'b1,8'h03,1'b0}, // R8 runs
    '{3'd3,3'd5,1'b1,1'b0,8'h01,8'h02,1'b0,8'h03,1'b0}, // R7 cmp suppressed
    '{3'd3,3'd4,1'b0,1'b1,8'h07,8'h07,1'b0,8'h03,1'b1}, // R8 cmp runs
    '{3'd4,3'd2,1'b0,1'b1,8'h0F,8'hF0,1'b0,8'h03,1'b1}, // R8 fails
    '{3'd4,3'd2,1'b1,1'b0,8'h0F,8'hF0,1'b1,8'hFF,1'b1}, // R7 runs
    '{3'd4,3'd0,1'b1,1'b1,8'h0F,8'h0F,1'b0,8'hFF,1'b1}, // R8 both never
    '{3'd4,3'd0,1'b0,1'b0,8'hAA,8'h55,1'b1,8'h00,1'b1}, // R6 logic keeps flag
    '{3'd5,3'd1,1'b0,1'b0,8'h12,8'h34,1'b0,8'h00,1'b1}, // R9
    '{3'd0,3'd0,1'b0,1'b0,8'h12,8'h34,1'b0,8'h00,1'b1}, // R9
    '{3'd3,3'd2,1'b1,1'b1,8'h01,8'h02,1'b0,8'h00,1'b1}, // R8 both never cmp
    '{3'd4,3'd4,1'b0,1'b0,8'h5A,8'h08,1'b1,8'h5A,1'b1}, // R2 amount masks to 0
    '{3'd4,3'd7,1'b0,1'b0,8'h01,8'h0F,1'b1,8'h02,1'b1}  // R3 ror by 7
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issue = 1'b0;
  logic [2:0] opcode = '0;
  logic [2:0] group = '0;
  logic condSet = 1'b0;
  logic condClear = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [7:0] result;
  logic resultWe;
  logic trFlag;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pred_alu #(.DATA_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .issue(issue), .opcode(opcode), .group(group),
    .condSet(condSet), .condClear(condClear), .opA(opA), .opB(opB),
    .result(result), .resultWe(resultWe), .trFlag(trFlag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runOp(input vec_t v);
    @(negedge clk);
    opcode = v.op; group = v.grp; condSet = v.cs; condClear = v.cc;
    opA = v.a; opB = v.b; issue = 1'b1;
    @(posedge clk);
    #1 issue = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 we", {7'd0, resultWe}, 8'd0);
    check("R10 tr", {7'd0, trFlag}, 8'd0);
    check("R10 result", result, 8'd0);
    @(negedge clk) rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      runOp(VECS[i]);
      check($sformatf("vector %0d R1-R9 we", i), {7'd0, resultWe}, {7'd0, VECS[i].expWe});
      check($sformatf("vector %0d R1-R9 result", i), result, VECS[i].expRes);
      check($sformatf("vector %0d R4-R8 flag", i), {7'd0, trFlag}, {7'd0, VECS[i].expTr});
      @(posedge clk);
      #1;
      check("R11 strobe single cycle", {7'd0, resultWe}, 8'd0);
      check("R11 result held", result, VECS[i].expRes);
    end
    // R10 asynchronous reset mid-run with the flag and result nonzero
    @(negedge clk) rstN = 1'b0;
    #1;
    check("R10 async tr", {7'd0, trFlag}, 8'd0);
    check("R10 async result", result, 8'd0);
    @(negedge clk) rstN = 1'b1;
    // R11 back-to-back issue: two writes in consecutive cycles
    @(negedge clk);
    opcode = 3'd4; group = 3'd1; condSet = 1'b0; condClear = 1'b0;
    opA = 8'h01; opB = 8'h80; issue = 1'b1;
    @(posedge clk);
    #1 opA = 8'h02; opB = 8'h04;
    check("R11 first result", result, 8'h81);
    @(posedge clk);
    #1 issue = 1'b0;
    check("R11 second result", result, 8'h06);
    check("R11 second we", {7'd0, resultWe}, 8'd1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule